// File: doc/BRIEF.md
# Two-Bank Synchronous DRAM Command Tracker

This block sits at the command input of a two-bank synchronous graphics memory. On every rising clock edge it samples clock enable, chip select, the three active-low row/column/write strobes, a special-function strobe and an 11-bit address. It turns these into one of five commands: activate, read, write, precharge or no-operation. It tracks which banks hold an open row and which row that is. It times read and write bursts of a fixed length and closes a bank on its own once a burst finishes, when the command asked for that. It also handles clock suspension and power-down, both driven by clock enable.

The two top address bits carry control information. The highest bit picks the bank. The next one either asks for a precharge of both banks or asks for an automatic precharge after a burst. Downstream logic reads the registered decoded command, the bank, the row or column address, the per-bank open flags and stored rows, an error pulse, a burst-busy flag and a power-down flag.

Top module: `dual_bank_cmd_tracker`

## Requirements
- R1: After reset, cmdOut is 0 (no-operation), bankOut, addrOut and every bankOpen bit are 0, and errFlag, burstBusy and powerDown are low.
- R2: The clock enable sampled on one edge decides whether the next edge is valid. Reset leaves the first edge valid. On an invalid edge no command is accepted (cmdOut shows 0), the bank state does not change and the burst count is frozen.
- R3: Power-down starts when clock enable is sampled low while no burst is running. powerDown is then high from that edge on, stays high as long as clock enable stays low, and drops at the first edge that samples clock enable high.
- R4: When chip select is high or the special-function strobe is high, the edge decodes as no-operation and no bank state changes. A burst already running keeps counting.
- R5: The strobes {ras,cas,we} (active low) decode as follows: 011 is activate (cmdOut 1), 101 is read (2), 100 is write (3), 010 is precharge (4), and every other pattern is no-operation (0). Address bit 10 selects the bank (0 for bank A, which is index 0, and 1 for bank B, which is index 1). An activate marks that bank open and stores address bits 9..0 as its row, in openRows[10*b+9:10*b]. addrOut shows that row one edge later.
- R6: A read or write to an open bank puts address bits 7..0, zero-extended, on addrOut, and address bits 8 and 9 do not appear there. burstBusy is then high for BURST_LEN cycles after the command edge, counting valid edges only.
- R7: A precharge with address bit 9 low closes only the bank that bit 10 selects. With bit 9 high it closes both banks.
- R8: A read or write with address bit 9 high closes its bank on the edge where the burst ends, which is the same edge on which burstBusy drops.
- R9: A read or write to a bank that is not open raises errFlag for one cycle and starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable for the following edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function strobe; high makes the edge a no-operation |
| addr | input | 11 | Address: bit 10 selects the bank, bit 9 is the precharge/auto-precharge control, bits 9..0 carry the row and bits 7..0 the column |
| cmdOut | output | 3 | Registered decoded command code |
| bankOut | output | 1 | Bank of the decoded command |
| addrOut | output | 10 | Row (activate) or zero-extended column (read/write) |
| bankOpen | output | 2 | Per-bank open flag |
| openRows | output | 20 | Stored open row of each bank, bank 0 in the low bits |
| errFlag | output | 1 | Pulse for a read or write to an idle bank |
| burstBusy | output | 1 | A burst is in progress |
| powerDown | output | 1 | Power-down state |

## Verification
The hardest case to reach is a burst frozen partway through by clock suspension. Clock enable has to drop one edge before the suspension takes effect, and the burst must still be running when it does, so that power-down is not entered instead. The stimulus opens a bank, issues a write, lets one beat pass, and then holds clock enable low for several edges. During that window it drives an activate, which must be ignored. It then raises clock enable again and counts edges until burstBusy drops. A separate scenario drives clock enable low with no burst running and checks that commands stay locked out until clock enable returns.

// File: rtl/cmd_tracker_pkg.sv
package cmd_tracker_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } cmdKind_t;

  // Strobes from control to datapath, one set per clock edge
  typedef struct packed {
    cmdKind_t               kind;
    logic                   bankSel;
    logic                   openRow;
    logic [NUM_BANKS-1:0]   closeMask;
    logic                   errIdle;
  } ctrlStrobes_t;

endpackage

// File: rtl/cmd_tracker_ctrl.sv
module cmd_tracker_ctrl
  import cmd_tracker_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 dsf,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output ctrlStrobes_t         strobes,
  output logic                 burstBusy,
  output logic                 powerDown
);

  localparam int BANK_BIT = ADDR_W - 1;
  localparam int CTRL_BIT = ADDR_W - 2;
  localparam int CNT_W    = $clog2(BURST_LEN + 1);

  logic             ckePrev;
  logic [CNT_W-1:0] burstCnt;
  logic             pendAuto;
  logic             pendBank;

  logic     edgeValid;
  logic     cmdSel;
  cmdKind_t kind;
  logic     bankSel;
  logic     isRw;
  logic     startBurst;
  logic     lastBeat;
  logic     applyAuto;
  logic [NUM_BANKS-1:0] oneHotSel;
  logic [NUM_BANKS-1:0] oneHotPend;

  assign edgeValid = ckePrev;
  assign cmdSel    = edgeValid && !csN && !dsf;
  assign bankSel   = addr[BANK_BIT];
  assign burstBusy = (burstCnt != '0);

  always_comb begin
    kind = CMD_NOP;
    if (cmdSel) begin
      unique case ({rasN, casN, weN})
        3'b011:  kind = CMD_ACT;
        3'b101:  kind = CMD_READ;
        3'b100:  kind = CMD_WRITE;
        3'b010:  kind = CMD_PRE;
        default: kind = CMD_NOP;
      endcase
    end
  end

  assign isRw       = (kind == CMD_READ) || (kind == CMD_WRITE);
  assign startBurst = isRw && bankOpen[bankSel];
  assign lastBeat   = edgeValid && (burstCnt == CNT_W'(1));
  assign applyAuto  = lastBeat && pendAuto && !startBurst;
  assign oneHotSel  = {{(NUM_BANKS-1){1'b0}}, 1'b1} << bankSel;
  assign oneHotPend = {{(NUM_BANKS-1){1'b0}}, 1'b1} << pendBank;

  always_comb begin
    strobes           = '0;
    strobes.kind      = kind;
    strobes.bankSel   = bankSel;
    strobes.openRow   = (kind == CMD_ACT);
    strobes.errIdle   = isRw && !bankOpen[bankSel];
    if (kind == CMD_PRE)
      strobes.closeMask = addr[CTRL_BIT] ? '1 : oneHotSel;
    if (applyAuto)
      strobes.closeMask = strobes.closeMask | oneHotPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev   <= 1'b1;
      powerDown <= 1'b0;
    end else begin
      ckePrev   <= cke;
      powerDown <= cke ? 1'b0 : (powerDown || !burstBusy);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCnt <= '0;
      pendAuto <= 1'b0;
      pendBank <= 1'b0;
    end else if (edgeValid) begin
      if (startBurst) begin
        burstCnt <= CNT_W'(BURST_LEN);
        pendAuto <= addr[CTRL_BIT];
        pendBank <= bankSel;
      end else if (burstBusy) begin
        burstCnt <= burstCnt - CNT_W'(1);
        if (lastBeat) pendAuto <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmd_tracker_dp.sv
module cmd_tracker_dp
  import cmd_tracker_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  ctrlStrobes_t                   strobes,
  output logic [2:0]                     cmdOut,
  output logic                           bankOut,
  output logic [ADDR_W-2:0]              addrOut,
  output logic [NUM_BANKS-1:0]           bankOpen,
  output logic [NUM_BANKS*(ADDR_W-1)-1:0] openRows,
  output logic                           errFlag
);

  localparam int ROW_W = ADDR_W - 1;

  logic [NUM_BANKS-1:0] nextOpen;
  logic [ROW_W-1:0]     nextAddr;

  always_comb begin
    nextOpen = bankOpen & ~strobes.closeMask;
    if (strobes.openRow) nextOpen[strobes.bankSel] = 1'b1;
  end

  always_comb begin
    unique case (strobes.kind)
      CMD_ACT:             nextAddr = addr[ROW_W-1:0];
      CMD_READ, CMD_WRITE: nextAddr = ROW_W'(addr[COL_W-1:0]);
      default:             nextAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankOpen <= '0;
      cmdOut   <= CMD_NOP;
      bankOut  <= 1'b0;
      addrOut  <= '0;
      errFlag  <= 1'b0;
    end else begin
      bankOpen <= nextOpen;
      cmdOut   <= strobes.kind;
      bankOut  <= (strobes.kind != CMD_NOP) ? strobes.bankSel : 1'b0;
      addrOut  <= nextAddr;
      errFlag  <= strobes.errIdle;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBankRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        openRows[b*ROW_W +: ROW_W] <= '0;
      else if (strobes.openRow && (strobes.bankSel == b[0]))
        openRows[b*ROW_W +: ROW_W] <= addr[ROW_W-1:0];
    end
  end

endmodule

// File: rtl/dual_bank_cmd_tracker.sv
module dual_bank_cmd_tracker
  import cmd_tracker_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cke,
  input  logic                    csN,
  input  logic                    rasN,
  input  logic                    casN,
  input  logic                    weN,
  input  logic                    dsf,
  input  logic [ADDR_W-1:0]       addr,
  output logic [2:0]              cmdOut,
  output logic                    bankOut,
  output logic [ADDR_W-2:0]       addrOut,
  output logic [1:0]              bankOpen,
  output logic [2*(ADDR_W-1)-1:0] openRows,
  output logic                    errFlag,
  output logic                    burstBusy,
  output logic                    powerDown
);

  ctrlStrobes_t strobes;

  cmd_tracker_ctrl #(
    .ADDR_W   (ADDR_W),
    .BURST_LEN(BURST_LEN)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .dsf      (dsf),
    .addr     (addr),
    .bankOpen (bankOpen),
    .strobes  (strobes),
    .burstBusy(burstBusy),
    .powerDown(powerDown)
  );

  cmd_tracker_dp #(
    .ADDR_W(ADDR_W),
    .COL_W (COL_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .strobes (strobes),
    .cmdOut  (cmdOut),
    .bankOut (bankOut),
    .addrOut (addrOut),
    .bankOpen(bankOpen),
    .openRows(openRows),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/cmd_tracker_checker.sv
module cmd_tracker_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic [2:0] cmdOut,
  input logic       bankOut,
  input logic [1:0] bankOpen,
  input logic       errFlag,
  input logic       burstBusy,
  input logic       powerDown
);

  AST_INVALID_EDGE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> ##2 (cmdOut == 3'd0)); // R2

  AST_INVALID_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> ##2 $stable(bankOpen)); // R2

  AST_PDN_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !burstBusy) |=> powerDown); // R3

  AST_PDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && !cke) |=> powerDown); // R3

  AST_PDN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> !powerDown); // R3

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 3'd1) |-> bankOpen[bankOut]); // R5

  AST_ERR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (cmdOut == 3'd2 || cmdOut == 3'd3)); // R9

endmodule

bind dual_bank_cmd_tracker cmd_tracker_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .cmdOut   (cmdOut),
  .bankOut  (bankOut),
  .bankOpen (bankOpen),
  .errFlag  (errFlag),
  .burstBusy(burstBusy),
  .powerDown(powerDown)
);

// File: tb/test_dual_bank_cmd_tracker.sv
`timescale 1ns/1ps
module test_dual_bank_cmd_tracker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cke, csN, rasN, casN, weN, dsf;
  logic [10:0] addr;
  logic [2:0]  cmdOut;
  logic        bankOut;
  logic [9:0]  addrOut;
  logic [1:0]  bankOpen;
  logic [19:0] openRows;
  logic        errFlag, burstBusy, powerDown;

  int vectors = 0;
  int miscompares = 0;

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                         S_PRE = 3'b010, S_NOP = 3'b111;

  always #5 clk = ~clk;

  dual_bank_cmd_tracker i_dual_bank_cmd_tracker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dsf(dsf), .addr(addr), .cmdOut(cmdOut), .bankOut(bankOut),
    .addrOut(addrOut), .bankOpen(bankOpen), .openRows(openRows),
    .errFlag(errFlag), .burstBusy(burstBusy), .powerDown(powerDown)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
    vectors++;
    if (actual !== expected) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  // drive one edge: inputs set at negedge, outputs checked at next negedge
  task automatic step(input logic ckeV, input logic csV, input logic [2:0] strb,
                      input logic dsfV, input logic [10:0] a);
    cke = ckeV; csN = csV; {rasN, casN, weN} = strb; dsf = dsfV; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    step(1'b1, 1'b0, S_NOP, 1'b0, 11'h000);
  endtask

  task automatic t_reset();
    check("R1", "cmdOut", cmdOut, 0);
    check("R1", "bankOpen", bankOpen, 0);
    check("R1", "addrOut", addrOut, 0);
    check("R1", "flags", {errFlag, burstBusy, powerDown}, 0);
  endtask

  task automatic t_activate();
    step(1'b1, 1'b0, S_ACT, 1'b0, {1'b0, 10'h155});
    check("R5", "act cmd", cmdOut, 1);
    check("R5", "act bank", bankOut, 0);
    check("R5", "act row out", addrOut, 10'h155);
    check("R5", "open after A", bankOpen, 2'b01);
    check("R5", "row A", openRows[9:0], 10'h155);
    step(1'b1, 1'b0, S_ACT, 1'b0, {1'b1, 10'h2AA});
    check("R5", "bank B", bankOut, 1);
    check("R5", "open after B", bankOpen, 2'b11);
    check("R5", "row B", openRows[19:10], 10'h2AA);
  endtask

  task automatic t_read();
    step(1'b1, 1'b0, S_RD, 1'b0, 11'h1C3);
    check("R6", "rd cmd", cmdOut, 2);
    check("R6", "column zero-ext", addrOut, 10'h0C3);
    check("R6", "busy at cmd", burstBusy, 1);
    for (int i = 0; i < 3; i++) begin
      nop();
      check("R6", "busy mid burst", burstBusy, 1);
    end
    nop();
    check("R6", "busy ends", burstBusy, 0);
    check("R6", "no auto close", bankOpen, 2'b11);
  endtask

  task automatic t_autopre();
    step(1'b1, 1'b0, S_RD, 1'b0, 11'h605);
    check("R8", "column", addrOut, 10'h005);
    for (int i = 0; i < 3; i++) begin
      nop();
      check("R8", "still open", bankOpen, 2'b11);
    end
    nop();
    check("R8", "closed at end", bankOpen, 2'b01);
    check("R8", "busy low", burstBusy, 0);
  endtask

  task automatic t_error();
    step(1'b1, 1'b0, S_RD, 1'b0, 11'h400);
    check("R9", "err rd idle", errFlag, 1);
    check("R9", "no burst", burstBusy, 0);
    nop();
    check("R9", "err pulse", errFlag, 0);
    step(1'b1, 1'b0, S_WR, 1'b0, 11'h410);
    check("R9", "err wr idle", errFlag, 1);
    check("R9", "no burst wr", burstBusy, 0);
    nop();
  endtask

  task automatic t_precharge();
    step(1'b1, 1'b0, S_ACT, 1'b0, {1'b1, 10'h001});
    check("R7", "both open", bankOpen, 2'b11);
    step(1'b1, 1'b0, S_PRE, 1'b0, 11'h000);
    check("R7", "pre cmd", cmdOut, 4);
    check("R7", "single close A", bankOpen, 2'b10);
    step(1'b1, 1'b0, S_ACT, 1'b0, {1'b0, 10'h0AA});
    check("R7", "reopen A", bankOpen, 2'b11);
    step(1'b1, 1'b0, S_PRE, 1'b0, 11'h200);
    check("R7", "close all", bankOpen, 2'b00);
  endtask

  task automatic t_ignore();
    step(1'b1, 1'b1, S_ACT, 1'b0, 11'h400);
    check("R4", "cs high nop", cmdOut, 0);
    check("R4", "cs high no open", bankOpen, 0);
    step(1'b1, 1'b0, S_ACT, 1'b1, 11'h400);
    check("R4", "dsf high nop", cmdOut, 0);
    check("R4", "dsf high no open", bankOpen, 0);
    step(1'b1, 1'b0, S_ACT, 1'b0, 11'h000);
    step(1'b1, 1'b0, S_WR, 1'b0, 11'h000);
    check("R4", "wr started", {cmdOut, burstBusy}, {3'd3, 1'b1});
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, S_ACT, 1'b0, 11'h400);
      check("R4", "burst runs with cs high", burstBusy, 1);
    end
    step(1'b1, 1'b1, S_ACT, 1'b0, 11'h400);
    check("R4", "burst ends with cs high", burstBusy, 0);
    check("R4", "bank B untouched", bankOpen, 2'b01);
  endtask

  task automatic t_suspend();
    step(1'b1, 1'b0, S_WR, 1'b0, 11'h000);
    nop();
    step(1'b0, 1'b0, S_NOP, 1'b0, 11'h000);
    check("R2", "busy before freeze", burstBusy, 1);
    step(1'b0, 1'b0, S_ACT, 1'b0, 11'h400);
    check("R2", "invalid edge nop", cmdOut, 0);
    check("R2", "invalid edge no open", bankOpen, 2'b01);
    check("R2", "suspend not pdn", powerDown, 0);
    step(1'b0, 1'b0, S_NOP, 1'b0, 11'h000);
    check("R2", "frozen busy", burstBusy, 1);
    nop();
    check("R2", "resume edge still frozen", burstBusy, 1);
    nop();
    check("R2", "last beat", burstBusy, 1);
    nop();
    check("R2", "burst done after resume", burstBusy, 0);
    check("R2", "no pdn", powerDown, 0);
  endtask

  task automatic t_powerdown();
    step(1'b0, 1'b0, S_NOP, 1'b0, 11'h000);
    check("R3", "pdn entered", powerDown, 1);
    step(1'b0, 1'b0, S_ACT, 1'b0, 11'h400);
    check("R3", "pdn held", powerDown, 1);
    check("R3", "act ignored in pdn", bankOpen, 2'b01);
    step(1'b0, 1'b0, S_NOP, 1'b0, 11'h000);
    check("R3", "pdn held 2", powerDown, 1);
    step(1'b1, 1'b0, S_ACT, 1'b0, 11'h400);
    check("R3", "pdn exit", powerDown, 0);
    check("R3", "exit edge invalid", bankOpen, 2'b01);
    step(1'b1, 1'b0, S_ACT, 1'b0, 11'h400);
    check("R3", "act after exit", bankOpen, 2'b11);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog R1..R9 actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = S_NOP;
    dsf = 1'b0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_activate();
    t_read();
    t_autopre();
    t_error();
    t_precharge();
    t_ignore();
    t_suspend();
    t_powerdown();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule